// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches the hot-plug detect line of a display output and turns it into clean interrupt events. The raw line is brought into the clock domain through a short synchronizer chain and then debounced by a filter whose behaviour comes from a programmable configuration register: a scale field sets how often the line is sampled, and a threshold field sets how many consecutive differing samples are needed before the filtered level changes.

Every change of the filtered level latches an event: one status bit for a plug-in (rising level) and another for an unplug (falling level). These latched events are combined with a live interrupt line from an attached display controller core into a single interrupt output, gated by an active-high enable mask. Software reads the status, clears events by writing ones, programs the mask and the filter, and reads the present filtered level, all through a plain single-cycle register port (write strobe, address, write data, combinational read data).

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset the status reads 0, the mask reads 0, the level register reads 0, the interrupt output is low and the filter register reads its reset values (threshold in bits 7:0, scale in bits 15:12, all other bits 0).
- R2: The filter register (address 0) holds the threshold in bits 7:0 and the scale in bits 15:12; a sample tick occurs every scale+1 cycles, and the filtered level takes the synchronized input only on the tick at which the input has differed from the level on threshold+1 consecutive ticks, the count restarting whenever input and level agree.
- R3: With scale 0 and the input passing through two synchronizer flops, a pulse on the hot-plug input lasting exactly threshold cycles leaves the filtered level unchanged, while one lasting threshold+1 cycles changes it.
- R4: A rise of the filtered level sets status bit 1 and a fall sets status bit 2 (status at address 1); each stays set until cleared.
- R5: Writing to address 2 clears exactly the latched status bits written as 1; address 2 reads 0.
- R6: The mask register (address 3, bits 2:0, read/write) is active high, and the interrupt output is the OR over status bits 2:0 of status AND mask.
- R7: Status bit 0 is the live core interrupt input, neither latched nor cleared by address 2.
- R8: When a clear and a new event hit the same status bit in the same cycle, the bit ends set.
- R9: Address 4 bit 0 reads the present filtered level (1 means a sink is connected); unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_i | input | 1 | Raw hot-plug detect line, asynchronous |
| core_irq_i | input | 1 | Interrupt from the attached controller core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data for reg_addr_i |
| irq_o | output | 1 | Merged, masked interrupt output |

## Verification
The bench builds the block with a reset threshold of 4 and a reset scale of 0 instead of the defaults, so the filter acts within a few cycles straight out of reset and a glitch of exactly threshold cycles and one of threshold+1 cycles can be placed precisely against the two-flop synchronizer. Reprogramming the filter to scale 1 then shows a pulse that a scale-0 filter would accept being rejected. The small threshold also lets a write-one-to-clear be aligned to the very cycle a rise event latches, reaching the clear-versus-set collision.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;

  // Register word address width and map
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_FILT = 3'd0;
  localparam logic [REG_AW-1:0] ADR_STAT = 3'd1;
  localparam logic [REG_AW-1:0] ADR_CLR  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_MASK = 3'd3;
  localparam logic [REG_AW-1:0] ADR_LVL  = 3'd4;

  // Interrupt source positions within status and mask
  localparam int SRC_CORE = 0;
  localparam int SRC_RISE = 1;
  localparam int SRC_FALL = 2;
  localparam int NUM_SRC  = 3;

  // Filter register field positions
  localparam int THR_LSB = 0;
  localparam int SCL_LSB = 12;

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hpd_filter.sv
module hpd_filter #(
  parameter int SCL_W = 4,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SCL_W-1:0] scale,
  input  logic [THR_W-1:0] thresh,
  output logic             level,
  output logic             rise,
  output logic             fall
);

  logic [SCL_W-1:0] pcnt;
  logic [THR_W-1:0] dcnt;
  logic             tick;
  logic             differ;
  logic             flip;

  assign tick   = (pcnt == scale);
  assign differ = (din != level);
  assign flip   = tick && differ && (dcnt >= thresh);

  // Sample tick prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  // Stability counter and filtered level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      level <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      rise <= flip && din;
      fall <= flip && !din;
      if (!differ) begin
        dcnt <= '0;
      end else if (tick) begin
        if (flip) begin
          level <= din;
          dcnt  <= '0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  // Level may move only on a tick where the input disagreed with it
  assert_level_needs_tick_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(tick) && ($past(din) != $past(level))));

  // A rise event flags exactly a 0->1 move of the level
  assert_rise_tracks_level_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level)));

  assert_fall_tracks_level_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

endmodule

// File: rtl/hpd_regs.sv
module hpd_regs
  import hpd_irq_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              SCL_W   = 4,
  parameter int              THR_W   = 8,
  parameter logic [THR_W-1:0] THR_RST = 8'hA0,
  parameter logic [SCL_W-1:0] SCL_RST = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              core_irq,
  input  logic              level,
  input  logic              rise_evt,
  input  logic              fall_evt,
  output logic [SCL_W-1:0]  scale,
  output logic [THR_W-1:0]  thresh,
  output logic              irq
);

  logic               stat_rise;
  logic               stat_fall;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] status;
  logic               clr_hit;

  assign clr_hit = wr_en && (addr == ADR_CLR);

  // Filter configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale  <= SCL_RST;
      thresh <= THR_RST;
    end else if (wr_en && (addr == ADR_FILT)) begin
      scale  <= wdata[SCL_LSB +: SCL_W];
      thresh <= wdata[THR_LSB +: THR_W];
    end
  end

  // Enable mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mask <= '0;
    else if (wr_en && (addr == ADR_MASK))   mask <= wdata[NUM_SRC-1:0];
  end

  // Latched events: a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_rise <= 1'b0;
      stat_fall <= 1'b0;
    end else begin
      stat_rise <= rise_evt | (stat_rise & ~(clr_hit & wdata[SRC_RISE]));
      stat_fall <= fall_evt | (stat_fall & ~(clr_hit & wdata[SRC_FALL]));
    end
  end

  always_comb begin
    status           = '0;
    status[SRC_CORE] = core_irq;
    status[SRC_RISE] = stat_rise;
    status[SRC_FALL] = stat_fall;
  end

  assign irq = |(status & mask);

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADR_FILT: begin
        rdata[SCL_LSB +: SCL_W] = scale;
        rdata[THR_LSB +: THR_W] = thresh;
      end
      ADR_STAT: rdata[NUM_SRC-1:0] = status;
      ADR_MASK: rdata[NUM_SRC-1:0] = mask;
      ADR_LVL:  rdata[0] = level;
      default:  rdata = '0;
    endcase
  end

  // Event seen in a cycle is always latched, clear or not
  assert_event_beats_clear_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    $past(rise_evt) |-> stat_rise);

  // Rise status bit only sets through an event
  assert_rise_needs_event_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (stat_rise && !$past(stat_rise)) |-> $past(rise_evt));

  // Fall status bit only drops through a matching clear write
  assert_fall_clear_only_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!stat_fall && $past(stat_fall)) |-> $past(clr_hit && wdata[SRC_FALL]));

  // Nothing enabled, nothing signalled
  assert_mask_gates_irq_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               SYNC_STAGES = 2,
  parameter int               SCL_W       = 4,
  parameter int               THR_W       = 8,
  parameter logic [THR_W-1:0] THR_RST     = 8'hA0,
  parameter logic [SCL_W-1:0] SCL_RST     = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_i,
  input  logic              core_irq_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic             hpd_sync_q;
  logic             hpd_level;
  logic             ev_rise;
  logic             ev_fall;
  logic [SCL_W-1:0] cfg_scale;
  logic [THR_W-1:0] cfg_thresh;

  hpd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hpd_i),
    .q     (hpd_sync_q)
  );

  hpd_filter #(
    .SCL_W (SCL_W),
    .THR_W (THR_W)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (hpd_sync_q),
    .scale  (cfg_scale),
    .thresh (cfg_thresh),
    .level  (hpd_level),
    .rise   (ev_rise),
    .fall   (ev_fall)
  );

  hpd_regs #(
    .DATA_W  (DATA_W),
    .SCL_W   (SCL_W),
    .THR_W   (THR_W),
    .THR_RST (THR_RST),
    .SCL_RST (SCL_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .rdata    (reg_rdata_o),
    .core_irq (core_irq_i),
    .level    (hpd_level),
    .rise_evt (ev_rise),
    .fall_evt (ev_fall),
    .scale    (cfg_scale),
    .thresh   (cfg_thresh),
    .irq      (irq_o)
  );

  // Rise and fall events never coincide
  assert_events_exclusive_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(ev_rise && ev_fall));

endmodule

// File: tb/hpd_irq_unit_tb_top.sv
module hpd_irq_unit_tb_top;

  localparam int DATA_W = 32;
  localparam int THR    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hpd = 1'b0;
  logic              core_irq = 1'b0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  always #2 clk = ~clk;  // 250 MHz

  hpd_irq_unit #(
    .DATA_W  (DATA_W),
    .THR_RST (8'(THR)),
    .SCL_RST (4'd0)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpd_i       (hpd),
    .core_irq_i  (core_irq),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  chk_stb = 1'b0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // Monitor: pops expectations and compares, away from the active edge
  always @(negedge clk) begin
    #1;
    if (chk_stb && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    chk_stb = 1'b1;
    @(negedge clk);
    chk_stb = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    chk_stb = 1'b1;
    @(negedge clk);
    chk_stb = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a low pulse of n cycles on an otherwise high hot-plug line
  task automatic low_pulse(input int n);
    @(negedge clk);
    hpd = 1'b0;
    repeat (n) @(negedge clk);
    hpd = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg(3'd1, 32'h0, "R1 status after reset");
    chk_reg(3'd3, 32'h0, "R1 mask after reset");
    chk_reg(3'd4, 32'h0, "R1 level after reset");
    chk_reg(3'd0, 32'h0000_0004, "R1 filter reset value");
    chk_irq(1'b0, "R1 irq low after reset");

    // R2 filter register fields
    wr(3'd0, 32'hFFFF_FFFF);
    chk_reg(3'd0, 32'h0000_F0FF, "R2 filter field readback");
    wr(3'd0, 32'h0000_0004);

    // R4 plug-in gives rise event, R9 level
    @(negedge clk); hpd = 1'b1;
    idle(20);
    chk_reg(3'd4, 32'h1, "R9 level high after plug");
    chk_reg(3'd1, 32'h2, "R4 rise latched");
    chk_irq(1'b0, "R6 masked rise keeps irq low");
    wr(3'd3, 32'h2);
    chk_irq(1'b1, "R6 enabled rise drives irq");
    chk_reg(3'd3, 32'h2, "R6 mask readback");
    chk_reg(3'd2, 32'h0, "R5 clear address reads 0");
    wr(3'd2, 32'h2);
    chk_reg(3'd1, 32'h0, "R5 rise cleared");
    chk_irq(1'b0, "R5 irq drops after clear");

    // R3 glitch boundary
    low_pulse(THR);
    idle(20);
    chk_reg(3'd4, 32'h1, "R3 pulse of thresh cycles keeps level");
    chk_reg(3'd1, 32'h0, "R3 pulse of thresh cycles gives no event");
    low_pulse(THR + 1);
    idle(20);
    chk_reg(3'd1, 32'h6, "R3 pulse of thresh+1 cycles gives fall and rise");
    chk_reg(3'd4, 32'h1, "R3 level back high");

    // R5 selective clear
    wr(3'd2, 32'h4);
    chk_reg(3'd1, 32'h2, "R5 only fall cleared");
    wr(3'd2, 32'h2);
    chk_reg(3'd1, 32'h0, "R5 rise cleared too");

    // R2 prescale: scale 1, threshold 2
    wr(3'd0, 32'h0000_1002);
    low_pulse(4);
    idle(20);
    chk_reg(3'd1, 32'h0, "R2 scaled filter rejects 4-cycle pulse");
    wr(3'd0, 32'h0000_0004);

    // R7 core interrupt pass-through
    wr(3'd3, 32'h0);
    @(negedge clk); core_irq = 1'b1;
    chk_reg(3'd1, 32'h1, "R7 core irq visible in status");
    chk_irq(1'b0, "R7 core irq masked");
    wr(3'd3, 32'h1);
    chk_irq(1'b1, "R7 core irq enabled");
    wr(3'd2, 32'h1);
    chk_reg(3'd1, 32'h1, "R7 core bit not cleared by write");
    @(negedge clk); core_irq = 1'b0;
    chk_irq(1'b0, "R7 core irq follows input");
    chk_reg(3'd1, 32'h0, "R7 core bit not latched");

    // R4 unplug gives fall event
    @(negedge clk); hpd = 1'b0;
    idle(20);
    chk_reg(3'd4, 32'h0, "R9 level low after unplug");
    chk_reg(3'd1, 32'h4, "R4 fall latched");
    wr(3'd3, 32'h4);
    chk_irq(1'b1, "R6 enabled fall drives irq");
    wr(3'd2, 32'h7);
    chk_reg(3'd1, 32'h0, "R5 clear all");

    // R8 clear in the same cycle the rise event latches
    wr(3'd3, 32'h2);
    @(negedge clk); hpd = 1'b1;
    repeat (THR + 3) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h2;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk_reg(3'd1, 32'h2, "R8 event wins over same-cycle clear");
    chk_irq(1'b1, "R8 irq stays asserted");
    chk_reg(3'd5, 32'h0, "R9 unused address reads 0");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule